// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block sits behind the bit-level receiver of an I2C slave and decides, byte by byte, whether the controller on the bus is talking to this device. After every start or repeated start it looks at the first received byte. It checks that byte against four 8-bit identity registers at the same time. Any register whose upper seven bits agree with the upper seven bits of the byte counts as a hit. Bit 0 of each identity register plays no part in this check.

When the wide-address mode input is high, two of the identity registers hold one packed 10-bit address instead. The upper register carries a fixed 11110b prefix in bits [7:3] and address bits [9:7] in bits [2:0]. The lower register carries address bits [6:0] in bits [7:1]. In this mode the recognizer accepts a header byte and then a low-address byte.

After a complete wide-address write match, a repeated start followed by a read header is accepted at once. This lets the controller turn the bus around without sending the low byte again. A stop forgets that earlier match. The host logic uses the acknowledge request to drive ACK on the bus, and uses the match flag, the identity index and the direction to steer the data phase.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, addr_match, ack_req, rw_dir and match_idx are all 0.
- R2: With ten_bit_en low, the first byte after a start matches when its bits [7:1] equal bits [7:1] of any of id0..id3. Bit 0 of the identity registers is ignored. addr_match rises on the clock edge that samples the byte.
- R3: When several identities hit, match_idx reports the lowest-numbered one as a binary index (0 for id0 up to 3 for id3). The index holds while addr_match stays high.
- R4: On a match, rw_dir takes bit 0 of the first address byte of the transfer (1 = read). It holds until the next match.
- R5: ack_req is a one-cycle pulse in the cycle after an accepted byte. It never follows a rejected byte, and it never follows a byte received after the address phase.
- R6: A rejected first byte makes the block ignore every further byte until the next start, even a byte that would match.
- R7: With ten_bit_en high, a first byte equal to {id1[7:1], 0} is acknowledged without setting addr_match. A following byte equal to {id1[0], id0[7:1]} sets addr_match with match_idx 0 and rw_dir 0. In this mode id2 and id3 take no part.
- R8: With ten_bit_en high, a wrong second byte gets no acknowledge and leaves addr_match low.
- R9: With ten_bit_en high, a read header {id1[7:1], 1} is rejected unless a full wide-address write match has happened since the last stop. If such a match has happened, the read header alone sets addr_match with rw_dir 1.
- R10: A stop clears addr_match and forgets any completed wide-address write match.
- R11: A start clears addr_match. A byte strobe in the same cycle as a start is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id0 | input | 8 | Identity register 0 (low part of the wide address) |
| id1 | input | 8 | Identity register 1 (prefix and high part of the wide address) |
| id2 | input | 8 | Identity register 2 |
| id3 | input | 8 | Identity register 3 |
| ten_bit_en | input | 1 | Selects the single 10-bit address mode |
| start_det | input | 1 | Start or repeated start seen on the bus |
| stop_det | input | 1 | Stop seen on the bus |
| byte_valid | input | 1 | One-cycle strobe: byte_data holds a received byte |
| byte_data | input | 8 | Received byte |
| addr_match | output | 1 | Device is addressed in the current transfer |
| match_idx | output | 2 | Index of the lowest matching identity |
| rw_dir | output | 1 | Captured direction, 1 = read |
| ack_req | output | 1 | Request to acknowledge the byte just received |

## Verification
A start indication and a byte strobe can arrive in the same cycle. This happens, for instance, when the receiver reports a repeated start together with a stray byte from the old transfer. The bench drives both strobes on the same falling edge with a byte that would match identity 0. It then expects no acknowledge and a low match flag. A clean byte after that must still be accepted, which shows that the start won and the block is waiting for a first byte.

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] id0,
  input  logic [BW-1:0] id1,
  input  logic [BW-1:0] id2,
  input  logic [BW-1:0] id3,
  input  logic          ten_bit_en,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          byte_valid,
  input  logic [BW-1:0] byte_data,
  output logic          addr_match,
  output logic [1:0]    match_idx,
  output logic          rw_dir,
  output logic          ack_req
);

  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_SECOND, S_HOLD} state_t;

  state_t        state;
  logic          armed;
  logic [3:0]    hit7;
  logic [1:0]    low_idx;
  logic          hdr_hit;
  logic          lo_hit;
  logic          take;

  assign hit7[0] = byte_data[BW-1:1] == id0[BW-1:1];
  assign hit7[1] = byte_data[BW-1:1] == id1[BW-1:1];
  assign hit7[2] = byte_data[BW-1:1] == id2[BW-1:1];
  assign hit7[3] = byte_data[BW-1:1] == id3[BW-1:1];

  always_comb begin
    low_idx = 2'd0;
    for (int i = 3; i >= 0; i--)
      if (hit7[i]) low_idx = 2'(i);
  end

  assign hdr_hit = byte_data[BW-1:1] == id1[BW-1:1];
  assign lo_hit  = byte_data == {id1[0], id0[BW-1:1]};
  assign take    = byte_valid && !start_det && !stop_det;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      armed      <= 1'b0;
      addr_match <= 1'b0;
      match_idx  <= 2'd0;
      rw_dir     <= 1'b0;
      ack_req    <= 1'b0;
    end else begin
      ack_req <= 1'b0;
      if (stop_det) begin
        state      <= S_IDLE;
        armed      <= 1'b0;
        addr_match <= 1'b0;
      end
      if (start_det) begin
        state      <= S_FIRST;
        addr_match <= 1'b0;
      end else if (take) begin
        case (state)
          S_FIRST: begin
            state <= S_HOLD;
            if (!ten_bit_en) begin
              if (|hit7) begin
                addr_match <= 1'b1;
                match_idx  <= low_idx;
                rw_dir     <= byte_data[0];
                ack_req    <= 1'b1;
              end
            end else if (hdr_hit && byte_data[0] && armed) begin
              addr_match <= 1'b1;
              match_idx  <= 2'd0;
              rw_dir     <= 1'b1;
              ack_req    <= 1'b1;
            end else if (hdr_hit && !byte_data[0]) begin
              state   <= S_SECOND;
              ack_req <= 1'b1;
            end
          end
          S_SECOND: begin
            state <= S_HOLD;
            if (lo_hit) begin
              addr_match <= 1'b1;
              match_idx  <= 2'd0;
              rw_dir     <= 1'b0;
              ack_req    <= 1'b1;
              armed      <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

module i2c_addr_match_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ten_bit_en,
  input logic       start_det,
  input logic       stop_det,
  input logic       byte_valid,
  input logic       addr_match,
  input logic [1:0] match_idx,
  input logic       rw_dir,
  input logic       ack_req
);
  p_ack_after_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> $past(byte_valid));
  p_rise_acked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_match) |-> ack_req);
  p_hold_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match && $past(addr_match) |-> $stable(match_idx) && $stable(rw_dir));
  p_start_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_det) |-> !addr_match && !ack_req);
  p_stop_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_det) |-> !addr_match && !ack_req);
  p_wide_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_match) && $past(ten_bit_en) |-> match_idx == 2'd0);
endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ten_bit_en(ten_bit_en), .start_det(start_det),
  .stop_det(stop_det), .byte_valid(byte_valid), .addr_match(addr_match),
  .match_idx(match_idx), .rw_dir(rw_dir), .ack_req(ack_req));

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;
  // {id0,id1,id2,id3,byte,match,idx[1:0],rw}
  localparam logic [43:0] VEC [NV] = '{
    44'hA0B2C4D6A1_9, 44'hA0B2C4D6C4_C, 44'hA0B2C4D6D7_F,
    44'hA0B2C4D612_0, 44'h3044444444_A, 44'h3044444445_B,
    44'h02045B065A_C, 44'h7E7E7E7E7F_9, 44'h1020304050_0};

  logic clk = 0, rst_n = 0;
  logic [7:0] id0 = 0, id1 = 0, id2 = 0, id3 = 0, byte_data = 0;
  logic ten_bit_en = 0, start_det = 0, stop_det = 0, byte_valid = 0;
  logic addr_match, rw_dir, ack_req;
  logic [1:0] match_idx;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_addr_match u_dut (.clk, .rst_n, .id0, .id1, .id2, .id3, .ten_bit_en,
    .start_det, .stop_det, .byte_valid, .byte_data, .addr_match, .match_idx,
    .rw_dir, .ack_req);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start_det = 1;
    @(negedge clk) start_det = 0;
  endtask

  task automatic do_stop();
    @(negedge clk) stop_det = 1;
    @(negedge clk) stop_det = 0;
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk) begin byte_valid = 1; byte_data = b; end
    @(negedge clk) byte_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 match", addr_match, 0); chk("R1 ack", ack_req, 0);
    chk("R1 rw", rw_dir, 0);        chk("R1 idx", match_idx, 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      {id0, id1, id2, id3, byte_data} = VEC[i][43:4];
      do_start();
      send(VEC[i][11:4]);
      chk("R2 match", addr_match, VEC[i][3]);
      chk("R5 ack", ack_req, VEC[i][3]);
      if (VEC[i][3]) begin
        chk("R3 idx", match_idx, VEC[i][2:1]);
        chk("R4 rw", rw_dir, VEC[i][0]);
      end
    end

    id0 = 8'hA0; id1 = 8'hB2; id2 = 8'hC4; id3 = 8'hD6;
    do_start(); send(8'hA0);
    @(negedge clk);
    chk("R5 ack pulse ends", ack_req, 0);
    send(8'hA0);
    chk("R5 data byte no ack", ack_req, 0);
    chk("R3 idx held", match_idx, 0);

    do_start(); send(8'h12);
    send(8'hB2);
    chk("R6 ignored ack", ack_req, 0);
    chk("R6 ignored match", addr_match, 0);

    do_start(); send(8'hC4);
    chk("R2 pre-stop", addr_match, 1);
    do_stop();
    chk("R10 stop clears", addr_match, 0);
    do_start();
    chk("R11 start clears", addr_match, 0);

    @(negedge clk) begin start_det = 1; byte_valid = 1; byte_data = 8'hA0; end
    @(negedge clk) begin start_det = 0; byte_valid = 0; end
    chk("R11 same-cycle ack", ack_req, 0);
    chk("R11 same-cycle match", addr_match, 0);
    send(8'hA0);
    chk("R11 after start", addr_match, 1);

    // 10-bit address 0x2A5: id0=4A, id1=F5, header F4/F5, low byte A5
    ten_bit_en = 1; id0 = 8'h4A; id1 = 8'hF5; id2 = 8'h44; id3 = 8'h44;
    do_stop();
    do_start(); send(8'hF5);
    chk("R9 unarmed read ack", ack_req, 0);
    chk("R9 unarmed read match", addr_match, 0);
    do_start(); send(8'h44);
    chk("R7 id2 unused", ack_req, 0);
    do_start(); send(8'hF4);
    chk("R7 header ack", ack_req, 1);
    chk("R7 header no match", addr_match, 0);
    send(8'hA5);
    chk("R7 low ack", ack_req, 1);
    chk("R7 match", addr_match, 1);
    chk("R7 idx", match_idx, 0);
    chk("R7 rw", rw_dir, 0);
    do_start(); send(8'hF5);
    chk("R9 armed read match", addr_match, 1);
    chk("R9 armed read ack", ack_req, 1);
    chk("R9 rw read", rw_dir, 1);
    do_stop(); do_start(); send(8'hF5);
    chk("R10 disarmed ack", ack_req, 0);
    chk("R10 disarmed match", addr_match, 0);
    do_start(); send(8'hF4); send(8'hA4);
    chk("R8 bad low ack", ack_req, 0);
    chk("R8 bad low match", addr_match, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule